// File: doc/BRIEF.md
# SFP Copper PHY Register Bridge over I2C

This block is an I2C master that gives on-chip logic read and write access to the 16-bit management registers of a copper PHY housed in an SFP module. A client presents a request, consisting of a direction flag, a 5-bit register number and 16 bits of write data. The bridge then runs one complete two-wire transaction on the module's open-drain clock and data lines. When the transaction finishes, it returns a one-cycle completion pulse, an error flag and, for reads, the 16-bit register value.

Every access moves one whole register as two bytes, most significant byte first, at a fixed device address.
- A write sends the address byte, a pointer byte and the two data bytes, then stops.
- A read sends the address byte and the pointer byte, then issues a repeated START. It follows with the address byte marked for reading and clocks in two bytes, acknowledging the first and not the second.

If the slave refuses any byte that the master sends, the transfer is cut short with a STOP and the error flag is raised. The bus clock comes from a divider of the system clock. One SCL period spans four equal quarter slots.

Top module: `sfp_phy_i2c_bridge`

## Requirements
- R1: While reset is held and after it is released with no request, neither bus line is pulled low, and busy, done and err are all low.
- R2: A write request with register n and data D produces, in order: START, byte 0xAC (device address 1010110 with R/W bit 0), pointer byte {3'b000, n}, D[15:8], D[7:0], STOP. Every byte is sent most significant bit first.
- R3: A read request with register n produces, in order: START, 0xAC, {3'b000, n}, a repeated START, 0xAD (R/W bit 1), two bytes clocked in from the slave, STOP. rdata then equals first byte * 256 + second byte.
- R4: During a read, the master holds SDA low in the ninth clock of the first data byte (ACK) and releases it in the ninth clock of the second data byte (NACK).
- R5: If the slave leaves SDA high in the ninth clock of the address, pointer or write-data byte, no further byte is sent, a STOP follows, and done is reported with err = 1. A transfer in which every sent byte is acknowledged reports err = 0.
- R6: SDA changes while SCL is high only to form START or STOP conditions. A write therefore contains exactly one START and one STOP, a completed read contains two STARTs and one STOP, and a read refused at the pointer byte contains one START and one STOP.
- R7: During a transfer, each SCL high phase and each SCL low phase lasts exactly 2 * QUARTER_CYC system clock cycles.
- R8: A request presented while busy is high is ignored. The transfer in progress continues with its original bytes, and no second transfer follows it.
- R9: busy rises in the cycle after a request is accepted and stays high until done. done is a one-cycle pulse, and busy is low in the cycle done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_reg | input | 5 | PHY register number |
| req_wdata | input | 16 | Data for a register write |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err | output | 1 | Last transfer was refused by the slave; valid with done |
| rdata | output | 16 | Register value from the last successful read |
| scl_drive_low | output | 1 | 1 pulls the SCL line low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls the SDA line low, 0 releases it |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
The bench builds the bridge with QUARTER_CYC = 4, so one SCL period is 16 system clocks and a complete read takes under 800 cycles. At that rate the bench can write and read back every one of the 32 register numbers against a behavioural slave within the run. It also injects a refusal at each byte position that a slave can refuse, in both directions. Expected bytes, data words and phase widths are computed from the register number and data in the bench.

// File: rtl/sfpi2c_pkg.sv
package sfpi2c_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bus_op_e;

  localparam logic [6:0] PHY_DEV_ADDR = 7'b1010110;
  localparam int         REG_W        = 5;
  localparam int         DATA_W       = 16;

  function automatic logic [7:0] pointer_byte(input logic [REG_W-1:0] regno);
    return {3'b000, regno};
  endfunction

endpackage

// File: rtl/sfpi2c_tick.sv
module sfpi2c_tick #(
  parameter int QUARTER_CYC = 125
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (QUARTER_CYC > 1) ? $clog2(QUARTER_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R7: quarter slots are separated, so no two ticks touch
  p_tick_gap_r7: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/sfpi2c_bitctl.sv
module sfpi2c_bitctl
  import sfpi2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       cmd_valid,
  input  bus_op_e    cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_ack,
  input  logic       sda_in,
  output logic       scl_rel,
  output logic       sda_rel,
  output logic       op_done,
  output logic [7:0] rx_byte,
  output logic       rx_nack
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic       active;
  bus_op_e    op_q;
  logic [1:0] qtr;
  logic [3:0] bitn;
  logic [7:0] shreg;
  logic       ack_q;
  logic       sda_s1, sda_s2;
  logic       is_cond;
  logic       drive_bit;
  logic       last_slot;

  assign rx_byte = shreg;
  assign is_cond = (op_q == OP_START) || (op_q == OP_STOP);

  always_comb begin
    if (op_q == OP_WRITE) drive_bit = (bitn == ACK_SLOT) ? 1'b1 : shreg[7];
    else                  drive_bit = (bitn == ACK_SLOT) ? !ack_q : 1'b1;
  end

  assign last_slot = (qtr == 2'd3) && (is_cond || bitn == ACK_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_s1 <= 1'b1;
      sda_s2 <= 1'b1;
    end else begin
      sda_s1 <= sda_in;
      sda_s2 <= sda_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      op_q    <= OP_STOP;
      qtr     <= 2'd0;
      bitn    <= 4'd0;
      shreg   <= 8'd0;
      ack_q   <= 1'b0;
      scl_rel <= 1'b1;
      sda_rel <= 1'b1;
      op_done <= 1'b0;
      rx_nack <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (!active) begin
        if (cmd_valid) begin
          active  <= 1'b1;
          op_q    <= cmd_op;
          qtr     <= 2'd0;
          bitn    <= 4'd0;
          shreg   <= cmd_byte;
          ack_q   <= cmd_ack;
          rx_nack <= 1'b0;
        end
      end else if (tick) begin
        case (op_q)
          OP_START: begin
            case (qtr)
              2'd0: sda_rel <= 1'b1;
              2'd1: scl_rel <= 1'b1;
              2'd2: sda_rel <= 1'b0;
              default: scl_rel <= 1'b0;
            endcase
          end
          OP_STOP: begin
            case (qtr)
              2'd0: begin
                scl_rel <= 1'b0;
                sda_rel <= 1'b0;
              end
              2'd1: scl_rel <= 1'b1;
              2'd2: sda_rel <= 1'b1;
              default: scl_rel <= 1'b1;
            endcase
          end
          default: begin
            case (qtr)
              2'd0: begin
                scl_rel <= 1'b0;
                sda_rel <= drive_bit;
              end
              2'd1: scl_rel <= 1'b1;
              2'd2: begin
                if (bitn != ACK_SLOT) shreg <= {shreg[6:0], sda_s2};
                else if (op_q == OP_WRITE) rx_nack <= sda_s2;
              end
              default: begin
                scl_rel <= 1'b0;
                if (bitn != ACK_SLOT) bitn <= bitn + 4'd1;
              end
            endcase
          end
        endcase
        qtr <= qtr + 2'd1;
        if (last_slot) begin
          active  <= 1'b0;
          op_done <= 1'b1;
        end
      end
    end
  end

  // R6: with SCL high on both sides of an edge, SDA may only move inside a START or STOP
  p_sda_still_scl_high_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(scl_rel) && scl_rel && (sda_rel != $past(sda_rel)))
      |-> ($past(op_q) == OP_START || $past(op_q) == OP_STOP));

  // R2: the sequencer only hands over a step while the engine is free
  p_cmd_when_free_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !active);

endmodule

// File: rtl/sfpi2c_seq.sv
module sfpi2c_seq
  import sfpi2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              op_done,
  input  logic [7:0]        rx_byte,
  input  logic              rx_nack,
  output logic              cmd_valid,
  output bus_op_e           cmd_op,
  output logic [7:0]        cmd_byte,
  output logic              cmd_ack,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_AW, S_PTR, S_WHI, S_WLO,
    S_RS, S_AR, S_RHI, S_RLO, S_STOP
  } step_e;

  step_e             st, nxt;
  logic              wr_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] wd_q;
  logic [7:0]        hi_q, lo_q;
  logic              err_acc;
  logic              sent_byte;
  logic              refused;

  assign busy      = (st != S_IDLE);
  assign sent_byte = (st == S_AW) || (st == S_PTR) || (st == S_WHI) ||
                     (st == S_WLO) || (st == S_AR);
  assign refused   = sent_byte && rx_nack;

  always_comb begin
    cmd_op   = OP_WRITE;
    cmd_byte = 8'd0;
    cmd_ack  = 1'b1;
    case (st)
      S_START, S_RS: cmd_op = OP_START;
      S_STOP:        cmd_op = OP_STOP;
      S_AW:          cmd_byte = {PHY_DEV_ADDR, 1'b0};
      S_PTR:         cmd_byte = pointer_byte(reg_q);
      S_WHI:         cmd_byte = wd_q[15:8];
      S_WLO:         cmd_byte = wd_q[7:0];
      S_AR:          cmd_byte = {PHY_DEV_ADDR, 1'b1};
      S_RHI:         cmd_op = OP_READ;
      S_RLO: begin
        cmd_op  = OP_READ;
        cmd_ack = 1'b0;
      end
      default: cmd_op = OP_WRITE;
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      S_START: nxt = S_AW;
      S_AW:    nxt = refused ? S_STOP : S_PTR;
      S_PTR:   nxt = refused ? S_STOP : (wr_q ? S_WHI : S_RS);
      S_WHI:   nxt = refused ? S_STOP : S_WLO;
      S_WLO:   nxt = S_STOP;
      S_RS:    nxt = S_AR;
      S_AR:    nxt = refused ? S_STOP : S_RHI;
      S_RHI:   nxt = S_RLO;
      S_RLO:   nxt = S_STOP;
      S_STOP:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
      err_acc   <= 1'b0;
      wr_q      <= 1'b0;
      reg_q     <= '0;
      wd_q      <= '0;
      hi_q      <= 8'd0;
      lo_q      <= 8'd0;
    end else begin
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          wr_q      <= req_write;
          reg_q     <= req_reg;
          wd_q      <= req_wdata;
          err_acc   <= 1'b0;
          st        <= S_START;
          cmd_valid <= 1'b1;
        end
      end else if (op_done) begin
        st <= nxt;
        if (refused) err_acc <= 1'b1;
        if (st == S_RHI) hi_q <= rx_byte;
        if (st == S_RLO) lo_q <= rx_byte;
        if (nxt == S_IDLE) begin
          done <= 1'b1;
          err  <= err_acc;
          if (!wr_q && !err_acc) rdata <= {hi_q, lo_q};
        end else begin
          cmd_valid <= 1'b1;
        end
      end
    end
  end

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: the bridge is free again when it reports completion
  p_done_free_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R5: a refused byte sends the sequencer straight to STOP
  p_refuse_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (op_done && refused) |=> (st == S_STOP));

  // R8: a request arriving mid-transfer does not disturb the latched register number
  p_hold_req_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> $stable(reg_q));

endmodule

// File: rtl/sfp_phy_i2c_bridge.sv
module sfp_phy_i2c_bridge
  import sfpi2c_pkg::*;
#(
  parameter int QUARTER_CYC = 125
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata,
  output logic        scl_drive_low,
  output logic        sda_drive_low,
  input  logic        sda_in
);
  logic       tick;
  logic       cmd_valid;
  bus_op_e    cmd_op;
  logic [7:0] cmd_byte;
  logic       cmd_ack;
  logic       op_done;
  logic [7:0] rx_byte;
  logic       rx_nack;
  logic       scl_rel;
  logic       sda_rel;

  sfpi2c_tick #(.QUARTER_CYC(QUARTER_CYC)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  sfpi2c_bitctl u_bitctl (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .cmd_ack   (cmd_ack),
    .sda_in    (sda_in),
    .scl_rel   (scl_rel),
    .sda_rel   (sda_rel),
    .op_done   (op_done),
    .rx_byte   (rx_byte),
    .rx_nack   (rx_nack)
  );

  sfpi2c_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .op_done   (op_done),
    .rx_byte   (rx_byte),
    .rx_nack   (rx_nack),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .cmd_ack   (cmd_ack),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rdata     (rdata)
  );

  assign scl_drive_low = !scl_rel;
  assign sda_drive_low = !sda_rel;

  // R1: an idle bridge leaves both lines released
  p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_drive_low && !sda_drive_low));

endmodule

// File: tb/sfp_phy_i2c_bridge_bench.sv
`timescale 1ns/1ps
module sfp_phy_i2c_bridge_bench;
  localparam int Q  = 4;
  localparam int HW = 2 * Q;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [4:0]  req_reg;
  logic [15:0] req_wdata;
  logic        busy, done, err;
  logic [15:0] rdata;
  logic        scl_drive_low, sda_drive_low;
  logic        s_drv;
  logic        scl_l, sda_l;

  assign scl_l = !scl_drive_low;
  assign sda_l = !sda_drive_low && !s_drv;

  always #2.5 clk = ~clk;

  sfp_phy_i2c_bridge #(.QUARTER_CYC(Q)) u_sfp_phy_i2c_bridge (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_write (req_write),
    .req_reg (req_reg), .req_wdata (req_wdata),
    .busy (busy), .done (done), .err (err), .rdata (rdata),
    .scl_drive_low (scl_drive_low), .sda_drive_low (sda_drive_low),
    .sda_in (sda_l)
  );

  // ---------------- behavioural slave ----------------
  int          cyc = 0;
  logic        p_scl, p_sda;
  int          bitcnt, txn_idx, tx_i;
  bit          tx, pend, tx_stop, rs_seen, fall_seen, nk;
  logic [7:0]  shr, txb, wr_hi;
  logic [4:0]  sptr;
  logic [15:0] sreg [0:31];
  logic [7:0]  rx_log [0:1023];
  logic        mack_log [0:255];
  int          rx_n = 0, mack_n = 0, starts = 0, stops = 0, wbad = 0;
  int          rise_t, fall_t;
  int          nack_at = -1;

  function automatic logic [15:0] init_val(input int r);
    return 16'(32'h1000 + r * 32'h0203);
  endfunction

  function automatic logic [15:0] wval(input int r);
    return 16'((r * 32'h1357) ^ 32'hC0DE);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      p_scl = 1'b1; p_sda = 1'b1; bitcnt = 0; txn_idx = 0; tx_i = 0;
      tx = 0; pend = 0; tx_stop = 0; rs_seen = 0; fall_seen = 0;
      sptr = '0; s_drv <= 1'b0;
      for (int i = 0; i < 32; i++) sreg[i] = init_val(i);
    end else begin
      if (p_scl && scl_l && p_sda && !sda_l) begin
        starts++;
        rs_seen = (txn_idx != 0);
        bitcnt = 0; tx = 0; pend = 0;
        s_drv <= 1'b0;
      end else if (p_scl && scl_l && !p_sda && sda_l) begin
        stops++;
        bitcnt = 0; tx = 0; pend = 0; tx_stop = 0; rs_seen = 0;
        txn_idx = 0; tx_i = 0;
        s_drv <= 1'b0;
      end else if (!p_scl && scl_l) begin
        if (fall_seen && (cyc - fall_t) != HW) wbad++;
        if (bitcnt < 8) shr = {shr[6:0], sda_l};
        else if (bitcnt == 8 && tx) begin
          mack_log[mack_n % 256] = sda_l;
          mack_n++;
          tx_stop = sda_l;
        end
        bitcnt++;
        rise_t = cyc;
      end else if (p_scl && !scl_l) begin
        if (bitcnt >= 1 && (cyc - rise_t) != HW) wbad++;
        fall_seen = 1;
        fall_t = cyc;
        if (bitcnt == 8) begin
          if (!tx) begin
            nk = (txn_idx == nack_at);
            rx_log[rx_n % 1024] = shr;
            rx_n++;
            if (txn_idx == 1) sptr = shr[4:0];
            if (txn_idx == 2) wr_hi = shr;
            if (!nk && txn_idx == 3) sreg[sptr] = {wr_hi, shr};
            if (!nk && rs_seen && shr == 8'hAD) pend = 1;
            txn_idx++;
            s_drv <= !nk;
          end else begin
            s_drv <= 1'b0;
          end
        end else if (bitcnt == 9) begin
          bitcnt = 0;
          if (pend || (tx && !tx_stop && tx_i < 2)) begin
            tx = 1; pend = 0;
            txb = (tx_i == 0) ? sreg[sptr][15:8] : sreg[sptr][7:0];
            tx_i++;
            s_drv <= !txb[7];
          end else begin
            tx = 0;
            s_drv <= 1'b0;
          end
        end else if (tx && bitcnt >= 1 && bitcnt <= 7) begin
          s_drv <= !txb[7 - bitcnt];
        end
      end
      p_scl = scl_l;
      p_sda = sda_l;
    end
  end

  // ---------------- checking ----------------
  int total = 0, bad = 0;
  bit finished = 0;
  int b_rx, b_mk, b_st, b_sp;
  logic        t_err;
  logic [15:0] t_rd;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input bit wr, input int r, input logic [15:0] wd,
                     input int nkat, input bit poke);
    int n;
    b_rx = rx_n; b_mk = mack_n; b_st = starts; b_sp = stops;
    nack_at = nkat;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_reg = 5'(r); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      req_valid = 1'b1; req_write = !wr; req_reg = 5'(r + 3); req_wdata = ~wd;
      @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R9", "done reached", int'(done), 1);
    chk(busy == 1'b0, "R9", "busy low at done", int'(busy), 0);
    t_err = err;
    t_rd  = rdata;
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", int'(done), 0);
    nack_at = -1;
  endtask

  task automatic chk_byte(input string req, input int k, input logic [7:0] exp);
    logic [7:0] got;
    got = rx_log[(b_rx + k) % 1024];
    chk(got == exp, req, $sformatf("byte %0d", k), int'(got), int'(exp));
  endtask

  task automatic check_write(input int r, input logic [15:0] v);
    run(1'b1, r, v, -1, 1'b0);
    chk(rx_n - b_rx == 4, "R2", "write byte count", rx_n - b_rx, 4);
    chk_byte("R2", 0, 8'hAC);
    chk_byte("R2", 1, {3'b000, 5'(r)});
    chk_byte("R2", 2, v[15:8]);
    chk_byte("R2", 3, v[7:0]);
    chk(t_err == 1'b0, "R5", "write err clear", int'(t_err), 0);
    chk(starts - b_st == 1 && stops - b_sp == 1, "R6", "write start/stop",
        (starts - b_st) * 16 + (stops - b_sp), 17);
  endtask

  task automatic check_read(input int r, input logic [15:0] v);
    run(1'b0, r, 16'h0000, -1, 1'b0);
    chk(rx_n - b_rx == 3, "R3", "read sent bytes", rx_n - b_rx, 3);
    chk_byte("R3", 0, 8'hAC);
    chk_byte("R3", 1, {3'b000, 5'(r)});
    chk_byte("R3", 2, 8'hAD);
    chk(t_rd == v, "R3", $sformatf("rdata reg %0d", r), int'(t_rd), int'(v));
    chk(t_err == 1'b0, "R5", "read err clear", int'(t_err), 0);
    chk(mack_n - b_mk == 2, "R4", "master ack count", mack_n - b_mk, 2);
    chk(mack_log[b_mk % 256] == 1'b0, "R4", "ack first byte",
        int'(mack_log[b_mk % 256]), 0);
    chk(mack_log[(b_mk + 1) % 256] == 1'b1, "R4", "nack second byte",
        int'(mack_log[(b_mk + 1) % 256]), 1);
    chk(starts - b_st == 2 && stops - b_sp == 1, "R6", "read start/stop",
        (starts - b_st) * 16 + (stops - b_sp), 33);
  endtask

  task automatic check_refuse(input bit wr, input int at, input int exp_rx,
                              input int exp_st);
    run(wr, 9, 16'hADAD, at, 1'b0);
    chk(t_err == 1'b1, "R5", $sformatf("err on refusal at %0d", at), int'(t_err), 1);
    chk(rx_n - b_rx == exp_rx, "R5", "bytes before abort", rx_n - b_rx, exp_rx);
    chk(stops - b_sp == 1, "R5", "stop after refusal", stops - b_sp, 1);
    chk(starts - b_st == exp_st, "R6", "starts on refusal", starts - b_st, exp_st);
  endtask

  initial begin
    int wb0, st0;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_reg = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!scl_drive_low && !sda_drive_low && !busy && !done && !err, "R1",
        "in reset", {scl_drive_low, sda_drive_low, busy, done, err}, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(!scl_drive_low && !sda_drive_low && !busy && !done && !err, "R1",
        "after reset", {scl_drive_low, sda_drive_low, busy, done, err}, 0);
    wb0 = wbad;

    check_read(5, init_val(5));
    for (int r = 0; r < 32; r++) begin
      check_write(r, wval(r));
      check_read(r, wval(r));
    end

    check_refuse(1'b1, 0, 1, 1);
    check_refuse(1'b1, 1, 2, 1);
    check_refuse(1'b1, 2, 3, 1);
    check_refuse(1'b1, 3, 4, 1);
    check_refuse(1'b0, 0, 1, 1);
    check_refuse(1'b0, 1, 2, 1);
    check_refuse(1'b0, 2, 3, 2);

    // R8: a second request during a write is ignored
    run(1'b1, 7, 16'h3C96, -1, 1'b1);
    chk(rx_n - b_rx == 4, "R8", "bytes with busy request", rx_n - b_rx, 4);
    chk_byte("R8", 1, 8'h07);
    chk_byte("R8", 2, 8'h3C);
    chk_byte("R8", 3, 8'h96);
    st0 = starts;
    repeat (300) @(negedge clk);
    chk(starts == st0 && !busy, "R8", "no follow-on transfer", starts - st0, 0);
    check_read(7, 16'h3C96);

    chk(wbad == wb0, "R7", "SCL phase widths", wbad - wb0, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule